// File: doc/BRIEF.md
# Flash command interface controller

This block is the command front end of a small NOR-style flash array, written as a synthesizable behavioural model. Bus write cycles deliver a command byte together with a word address. The byte chooses what later read cycles return: the contents of the array, the two identifier bytes, or the status byte. A two-write sequence, a setup command followed by a confirm command, erases one block. An internal timer stands in for the erase algorithm. When the timer expires, every word of the chosen block is set to all-ones.

Three fault kinds are recorded in sticky status bits: a broken command sequence, a low programming supply, and an attempt to erase the protected boot block. Once set, these bits stay set across later operations until a dedicated clear command is written. A ready/busy pin and the top status bit report whether an erase is running. The status byte seen on a read is the one captured when the output-enable and chip-enable strobes both become active. It changes only after a strobe goes inactive and the pair becomes active again.

Supply and protection conditions arrive as digital flags. The default array is 8 blocks of 16 sixteen-bit words. Block 0 is the boot block. Word addresses take the block number in bits [6:4] and the word offset in bits [3:0].

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in array-read mode, all sticky fault bits are 0, ry_by is 1, the latched status byte is 80H, and each word i holds the reset pattern ((i*123H) mod 10000H) XOR 3C5AH.
- R2: Writing FFH selects array reads, 90H selects identifier reads and 70H selects status reads, and the selected mode persists. Any other byte outside an erase sequence, including a lone D0H, leaves the mode unchanged.
- R3: In identifier mode a read at address 0 returns 00B0H, a read at address 1 returns 004CH, and a read at any other address returns 0000H.
- R4: In status mode rdata is {8'h00, status}. Status bit 7 is ready, bit 5 is the erase fault, bit 4 is the sequence fault, bit 3 is the supply fault and bit 1 is the protection fault. Bits 6, 2 and 0 read 0.
- R5: Writing 20H and then D0H erases the block selected by bits [6:4] of the confirm address. After completion every word of that block reads FFFFH and all other blocks are unchanged. Status mode is selected by the setup write and is still selected after completion.
- R6: ry_by is 0 and status bit 7 is 0 for exactly ERASE_CYCLES clock cycles, counting from the edge that samples the confirm write.
- R7: If the write after 20H is not D0H, status bits 4 and 5 are set, no erase takes place, and the mode becomes status reads. That byte is not decoded as a command.
- R8: A confirm while vpp_low is 1 sets status bits 3 and 5 and leaves the block unchanged. This check takes priority over the protection check.
- R9: A confirm to block 0 while wp_n is 0 and rp_hv is 0 sets status bits 1 and 5 and leaves the block unchanged. If wp_n or rp_hv is 1, the erase proceeds.
- R10: Fault bits accumulate across operations. Only writing 50H clears them, and that write does not change the read mode.
- R11: The status byte is captured at the first clock edge where ce_n and oe_n are both 0. It holds while both stay 0, even across the end of an erase.
- R12: While an erase is running, every write is ignored, including FFH. The block stays in status mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe, one cycle per command write |
| addr | input | 7 | Word address: block in [6:4], offset in [3:0] |
| wdata | input | 8 | Command byte |
| ce_n | input | 1 | Chip enable, active low (status capture) |
| oe_n | input | 1 | Output enable, active low (status capture) |
| vpp_low | input | 1 | Programming supply below the erase limit |
| wp_n | input | 1 | Boot block write protect, active low |
| rp_hv | input | 1 | Reset pin at high voltage (unlocks boot block) |
| rdata | output | 16 | Read data for the current mode |
| ry_by | output | 1 | 1 when ready, 0 while an erase runs |

## Verification
A command write takes effect at the edge that samples it. The new mode, any fault bits and the start of busy are all visible one cycle after the write strobe. An erased block reads all-ones starting in the cycle where ry_by returns high, which is ERASE_CYCLES cycles after the confirm. A status byte becomes visible in the cycle after both strobes are first seen low. The bench's behavioural model advances on each rising edge under the same rules. rdata and ry_by are compared against the model 1 ns after every edge, and directed reads are sampled at falling edges, once all of those registers have settled.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_READ_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_READ_IDENT    = 8'h90;
  localparam logic [7:0] CMD_READ_STATUS   = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP   = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;

  localparam logic [7:0] ID_MAKER  = 8'hB0;
  localparam logic [7:0] ID_DEVICE = 8'h4C;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  typedef struct packed {
    logic erase;
    logic seq;
    logic vpp;
    logic prot;
  } fault_t;

  // Status byte layout: ready, 0, erase, seq, vpp, 0, prot, 0
  function automatic logic [7:0] pack_status(logic busy, fault_t f);
    return {~busy, 1'b0, f.erase, f.seq, f.vpp, 1'b0, f.prot, 1'b0};
  endfunction

  // Reset contents of the array, never all-ones for the default size
  function automatic logic [15:0] init_word(int unsigned idx);
    logic [31:0] p;
    p = idx * 32'h0000_0123;
    return p[15:0] ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] ident_word(logic is_maker, logic is_device);
    if (is_maker)  return {8'h00, ID_MAKER};
    if (is_device) return {8'h00, ID_DEVICE};
    return 16'h0000;
  endfunction

endpackage

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int BLK_W    = 3,
  parameter int BOOT_BLK = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             wsm_busy,
  input  logic             vpp_low,
  input  logic             wp_n,
  input  logic             rp_hv,
  output rd_mode_e         mode,
  output logic             erase_go,
  output logic [BLK_W-1:0] erase_blk,
  output fault_t           fault_set,
  output logic             fault_clr
);

  rd_mode_e mode_q;
  logic     setup_q;

  // Named events for the assertions
  logic accept, confirm_cycle, cmd_cycle, is_confirm, boot_locked;

  assign accept        = wr_en & ~wsm_busy;
  assign confirm_cycle = accept & setup_q;
  assign cmd_cycle     = accept & ~setup_q;
  assign is_confirm    = (wr_data == CMD_ERASE_CONFIRM);
  assign boot_locked   = (wr_blk == BLK_W'(BOOT_BLK)) & ~wp_n & ~rp_hv;

  always_comb begin
    fault_set       = '0;
    fault_set.seq   = confirm_cycle & ~is_confirm;
    fault_set.vpp   = confirm_cycle & is_confirm & vpp_low;
    fault_set.prot  = confirm_cycle & is_confirm & ~vpp_low & boot_locked;
    fault_set.erase = fault_set.seq | fault_set.vpp | fault_set.prot;
  end

  assign erase_go  = confirm_cycle & is_confirm & ~vpp_low & ~boot_locked;
  assign erase_blk = wr_blk;
  assign fault_clr = cmd_cycle & (wr_data == CMD_CLEAR_STATUS);
  assign mode      = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= RD_ARRAY;
      setup_q <= 1'b0;
    end else if (confirm_cycle) begin
      setup_q <= 1'b0;
      mode_q  <= RD_STATUS;
    end else if (cmd_cycle) begin
      case (wr_data)
        CMD_READ_ARRAY:  mode_q <= RD_ARRAY;
        CMD_READ_IDENT:  mode_q <= RD_IDENT;
        CMD_READ_STATUS: mode_q <= RD_STATUS;
        CMD_ERASE_SETUP: begin
          setup_q <= 1'b1;
          mode_q  <= RD_STATUS;
        end
        default: ;
      endcase
    end
  end

  // R12: writes during an erase leave status reads selected
  p_busy_locks_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wsm_busy && wr_en) |=> (mode == RD_STATUS));

  // R7: a confirm cycle has at most one outcome
  p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_go, fault_set.seq, fault_set.vpp, fault_set.prot}));

  // R5: setup write selects status reads
  p_setup_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cycle && wr_data == CMD_ERASE_SETUP) |=> (mode == RD_STATUS));

endmodule

// File: rtl/flash_erase_wsm.sv
module flash_erase_wsm #(
  parameter int BLK_W        = 3,
  parameter int ERASE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [BLK_W-1:0] go_blk,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] done_blk
);

  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [BLK_W-1:0] blk_q;

  assign busy     = busy_q;
  assign done     = busy_q && (cnt_q == '0);
  assign done_blk = blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      blk_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(ERASE_CYCLES - 1);
      blk_q  <= go_blk;
    end
  end

  // R6: the decoder never starts an erase while one runs
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

  // R6: completion releases busy on the next cycle
  p_done_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  fault_t     fault_set,
  input  logic       fault_clr,
  input  logic       ce_n,
  input  logic       oe_n,
  output logic [7:0] sr_live,
  output logic [7:0] sr_latch
);

  fault_t sticky;
  logic   acc, acc_q, capture;

  assign acc     = ~ce_n & ~oe_n;
  assign capture = acc & ~acc_q;
  assign sr_live = pack_status(busy, sticky);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky   <= '0;
      acc_q    <= 1'b0;
      sr_latch <= pack_status(1'b0, '0);
    end else begin
      acc_q <= acc;
      if (fault_clr) sticky <= '0;
      else           sticky <= sticky | fault_set;
      if (capture)   sr_latch <= sr_live;
    end
  end

  // R10: fault bits only move on a set or a clear
  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_clr && fault_set == '0) |=> $stable(sticky));

  // R10: a clear empties every fault bit
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> (sticky == '0));

  // R11: the visible byte changes only on a new strobe pair
  p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(sr_latch));

endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_cmd_pkg::*;
#(
  parameter int BLK_W = 3,
  parameter int OFS_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fill,
  input  logic [BLK_W-1:0]       fill_blk,
  input  logic [BLK_W+OFS_W-1:0] rd_addr,
  output logic [15:0]            rd_data
);

  localparam int WORDS = 1 << (BLK_W + OFS_W);

  logic [15:0] mem [WORDS];

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= init_word(32'(i));
    end else if (fill) begin
      for (int i = 0; i < WORDS; i++)
        if (BLK_W'(i >> OFS_W) == fill_blk) mem[i] <= 16'hFFFF;
    end
  end

  // R5: the first word of the erased block reads all-ones afterwards
  p_fill_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (mem[{$past(fill_blk), {OFS_W{1'b0}}}] == 16'hFFFF));

  // R8: word 0 of the boot block moves only on an erase completion
  p_boot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fill |=> $stable(mem[0]));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int BLK_W        = 3,
  parameter int OFS_W        = 4,
  parameter int ERASE_CYCLES = 16,
  parameter int BOOT_BLK     = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [BLK_W+OFS_W-1:0] addr,
  input  logic [7:0]             wdata,
  input  logic                   ce_n,
  input  logic                   oe_n,
  input  logic                   vpp_low,
  input  logic                   wp_n,
  input  logic                   rp_hv,
  output logic [15:0]            rdata,
  output logic                   ry_by
);

  localparam int ADDR_W = BLK_W + OFS_W;

  rd_mode_e         mode;
  logic             erase_go, fault_clr, busy, done;
  logic [BLK_W-1:0] erase_blk, done_blk;
  fault_t           fault_set;
  logic [7:0]       sr_live, sr_latch;
  logic [15:0]      arr_data;

  flash_cmd_decoder #(.BLK_W(BLK_W), .BOOT_BLK(BOOT_BLK)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_data(wdata),
    .wr_blk(addr[ADDR_W-1:OFS_W]), .wsm_busy(busy), .vpp_low(vpp_low),
    .wp_n(wp_n), .rp_hv(rp_hv), .mode(mode), .erase_go(erase_go),
    .erase_blk(erase_blk), .fault_set(fault_set), .fault_clr(fault_clr)
  );

  flash_erase_wsm #(.BLK_W(BLK_W), .ERASE_CYCLES(ERASE_CYCLES)) u_wsm (
    .clk(clk), .rst_n(rst_n), .go(erase_go), .go_blk(erase_blk),
    .busy(busy), .done(done), .done_blk(done_blk)
  );

  flash_status_reg u_sr (
    .clk(clk), .rst_n(rst_n), .busy(busy), .fault_set(fault_set),
    .fault_clr(fault_clr), .ce_n(ce_n), .oe_n(oe_n),
    .sr_live(sr_live), .sr_latch(sr_latch)
  );

  flash_array #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .fill(done), .fill_blk(done_blk),
    .rd_addr(addr), .rd_data(arr_data)
  );

  assign ry_by = ~busy;

  always_comb begin
    case (mode)
      RD_IDENT:  rdata = ident_word(addr == '0, addr == ADDR_W'(1));
      RD_STATUS: rdata = {8'h00, sr_latch};
      default:   rdata = arr_data;
    endcase
  end

  // R6: pin and status bit agree on the ready state
  p_ready_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ry_by == sr_live[7]);

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, vpp_low = 1'b0, wp_n = 1'b1, rp_hv = 1'b0;
  logic [15:0] rdata;
  logic ry_by;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ERASE_CYCLES(N)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .ce_n(ce_n), .oe_n(oe_n), .vpp_low(vpp_low), .wp_n(wp_n),
    .rp_hv(rp_hv), .rdata(rdata), .ry_by(ry_by)
  );

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic ck(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mmem[128];
  int mmode, mcnt, mblk;
  bit msetup, mbusy, e5, e4, e3, e1, macc_q;
  int mlatch;

  function automatic int pattern(int i);
    return ((i * 291) % 65536) ^ 15450;
  endfunction

  function automatic int model_sr(bit b);
    return (b ? 0 : 128) + (e5 ? 32 : 0) + (e4 ? 16 : 0) + (e3 ? 8 : 0) + (e1 ? 2 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mmem[i]) mmem[i] = pattern(i);
      mmode = 0; msetup = 0; mbusy = 0; mcnt = 0; mblk = 0;
      e5 = 0; e4 = 0; e3 = 0; e1 = 0; macc_q = 0; mlatch = 128;
    end else begin
      bit ob, acc;
      int blk;
      ob = mbusy;
      acc = !ce_n && !oe_n;
      if (acc && !macc_q) mlatch = model_sr(ob);
      macc_q = acc;
      if (ob) begin
        if (mcnt == 0) begin
          for (int i = mblk * 16; i < mblk * 16 + 16; i++) mmem[i] = 65535;
          mbusy = 0;
        end else mcnt--;
      end else if (we) begin
        blk = int'(addr) / 16;
        if (msetup) begin
          msetup = 0; mmode = 2;
          if (wdata != 8'hD0) begin e4 = 1; e5 = 1; end
          else if (vpp_low) begin e3 = 1; e5 = 1; end
          else if (blk == 0 && !wp_n && !rp_hv) begin e1 = 1; e5 = 1; end
          else begin mbusy = 1; mcnt = N - 1; mblk = blk; end
        end else begin
          case (wdata)
            8'hFF: mmode = 0;
            8'h90: mmode = 1;
            8'h70: mmode = 2;
            8'h50: begin e5 = 0; e4 = 0; e3 = 0; e1 = 0; end
            8'h20: begin msetup = 1; mmode = 2; end
            default: ;
          endcase
        end
      end
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      case (mmode)
        0: ck("R5 array", rdata, 16'(mmem[addr]));
        1: ck("R3 ident", rdata, addr == 0 ? 16'h00B0 : (addr == 1 ? 16'h004C : 16'h0000));
        default: ck("R11 status", rdata, 16'(mlatch));
      endcase
      ck("R6 ry_by", {15'd0, ry_by}, {15'd0, !mbusy});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [7:0] d, logic [6:0] a);
    @(negedge clk); we = 1'b1; wdata = d; addr = a;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_status(string tag, logic [7:0] exp);
    @(negedge clk); oe_n = 1'b1; ce_n = 1'b0;
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk);
    ck(tag, rdata, {8'h00, exp});
  endtask

  task automatic rd_word(string tag, logic [6:0] a, logic [15:0] exp);
    @(negedge clk); addr = a; #1;
    ck(tag, rdata, exp);
  endtask

  task automatic wait_ready();
    while (ry_by !== 1'b1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd_word("R1 reset array", 7'd5, 16'(pattern(5)));
    ck("R1 ready", {15'd0, ry_by}, 16'd1);
    wr(8'h70, 7'd0);
    rd_status("R1 R4 reset status", 8'h80);
    // R3: identifier reads, R2: undefined codes
    wr(8'h90, 7'd0);
    rd_word("R3 maker", 7'd0, 16'h00B0);
    rd_word("R3 device", 7'd1, 16'h004C);
    rd_word("R3 other", 7'd7, 16'h0000);
    wr(8'h33, 7'd0);
    rd_word("R2 undefined ignored", 7'd1, 16'h004C);
    wr(8'hD0, 7'd0);
    rd_word("R2 lone confirm ignored", 7'd0, 16'h00B0);
    wr(8'hFF, 7'd0);
    rd_word("R2 array select", 7'd9, 16'(pattern(9)));
    // R5 R6: erase block 2 with busy length
    wr(8'h20, 7'h20);
    wr(8'hD0, 7'h25);
    n = 0;
    while (ry_by === 1'b0) begin n++; @(negedge clk); end
    ck("R6 busy cycles", 16'(n), 16'(N));
    rd_status("R5 done status", 8'h80);
    wr(8'hFF, 7'd0);
    for (int i = 32; i < 48; i++) rd_word("R5 block erased", 7'(i), 16'hFFFF);
    rd_word("R5 next block kept", 7'h30, 16'(pattern(48)));
    rd_word("R5 prev block kept", 7'h1F, 16'(pattern(31)));
    // R12: writes ignored during an erase
    wr(8'h20, 7'h60);
    wr(8'hD0, 7'h60);
    wr(8'hFF, 7'd0);
    wait_ready();
    rd_status("R12 still status", 8'h80);
    // R7: bad confirm, not decoded
    wr(8'h20, 7'h30);
    wr(8'hFF, 7'h30);
    rd_status("R7 seq fault", 8'hB0);
    // R8 R10: supply fault accumulates
    vpp_low = 1'b1;
    wr(8'h20, 7'h40);
    wr(8'hD0, 7'h40);
    rd_status("R8 R10 accumulate", 8'hB8);
    vpp_low = 1'b0;
    wr(8'h50, 7'd0);
    rd_status("R10 cleared, mode kept", 8'h80);
    wr(8'hFF, 7'd0);
    rd_word("R7 block kept", 7'h33, 16'(pattern(51)));
    rd_word("R8 block kept", 7'h44, 16'(pattern(68)));
    // R9: boot block protection
    wp_n = 1'b0; rp_hv = 1'b0;
    wr(8'h20, 7'h02);
    wr(8'hD0, 7'h02);
    rd_status("R9 protect fault", 8'hA2);
    vpp_low = 1'b1;
    wr(8'h20, 7'h02);
    wr(8'hD0, 7'h02);
    rd_status("R8 supply has priority", 8'hAA);
    vpp_low = 1'b0;
    wr(8'h50, 7'd0);
    wr(8'hFF, 7'd0);
    rd_word("R9 boot kept", 7'h02, 16'(pattern(2)));
    rp_hv = 1'b1;
    wr(8'h20, 7'h00);
    wr(8'hD0, 7'h00);
    wait_ready();
    rd_status("R9 unlocked erase", 8'h80);
    wr(8'hFF, 7'd0);
    rd_word("R9 boot erased", 7'h0F, 16'hFFFF);
    rp_hv = 1'b0; wp_n = 1'b1;
    // R11: latch holds across completion
    wr(8'h20, 7'h50);
    wr(8'hD0, 7'h50);
    rd_status("R11 busy captured", 8'h00);
    wait_ready();
    @(negedge clk);
    ck("R11 held while strobes low", rdata, 16'h0000);
    rd_status("R11 recaptured", 8'h80);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule